// File: doc/BRIEF.md
# Tile Binning and Bucket Dispatcher

This block spreads a frame's rasterization work over a pool of rasterizers in two phases. While binning, it accepts screen-space triangles, each carrying an index and three vertices. It computes each triangle's bounding box and appends the triangle index to the bucket of every tile of a fixed grid that the box touches. All touched buckets are written in the same cycle.

An end-of-frame pulse closes binning. The non-empty buckets then form a work queue. A rasterizer port that is free requests work and is handed a whole bucket: its tile number and its entry count. It reads the bucket's triangle indices through a small read port. When it finishes, it requests again. Once every bucket has gone out and every port has reported completion, the block pulses a frame-done output, clears its buckets and returns to binning.

Top module: `tile_binner`

## Requirements
- R1: Tiles are 32x32 pixels in a 6-wide by 4-high grid. Tile number = row*6 + column. A triangle is appended to every tile whose area intersects its vertex bounding box, and to no other tile. Boxes that reach past the grid are clipped, so an entirely off-grid triangle lands in no bucket.
- R2: Within a bucket, entries are kept in acceptance order. Slot 0 holds the earliest accepted triangle, and `rd_idx` returns the entry at `rd_tile`/`rd_slot`.
- R3: `tri_ready` is high only while binning. No grant is issued while binning. Triangles presented after the end-of-frame pulse are not accepted and alter no bucket.
- R4: At most one grant is issued per cycle, as a one-hot bit on `grant_vec`. It goes to the lowest-numbered eligible requesting port. Within a frame, buckets are granted in ascending tile order.
- R5: Empty buckets are never granted, so a frame produces exactly one grant per non-empty bucket and `grant_count` is never 0.
- R6: A port holds one bucket at a time. After a grant, the port is not eligible again until it raises `rast_req` to signal completion. It becomes eligible one cycle after that.
- R7: A bucket keeps at most 16 entries. Further entries for a full bucket are dropped, and `overflow_err` goes high and stays high until reset.
- R8: `frame_done` is a one-cycle pulse issued after all non-empty buckets are granted and every granted port has raised `rast_req`. Binning then resumes with all buckets empty. A frame with no entries completes with no grants.
- R9: After reset, `tri_ready` is 1 and `grant_vec`, `frame_done` and `overflow_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tri_valid | input | 1 | A triangle is presented |
| tri_ready | output | 1 | Binning phase; triangle taken when valid and ready |
| tri_id | input | 8 | Triangle index stored in buckets |
| v0_x | input | 10 | Vertex 0 x in pixels |
| v0_y | input | 10 | Vertex 0 y in pixels |
| v1_x | input | 10 | Vertex 1 x in pixels |
| v1_y | input | 10 | Vertex 1 y in pixels |
| v2_x | input | 10 | Vertex 2 x in pixels |
| v2_y | input | 10 | Vertex 2 y in pixels |
| frame_end | input | 1 | Pulse: all geometry of the frame has been sent |
| rast_req | input | 4 | Per port: free and asking for a bucket |
| grant_vec | output | 4 | One-hot pulse: port receiving a bucket |
| grant_tile | output | 5 | Tile number of the granted bucket |
| grant_count | output | 5 | Number of entries in the granted bucket |
| rd_tile | input | 5 | Bucket read: tile number |
| rd_slot | input | 4 | Bucket read: entry slot |
| rd_idx | output | 8 | Bucket read: triangle index |
| frame_done | output | 1 | Pulse: frame fully dispatched and completed |
| overflow_err | output | 1 | Sticky bucket overflow flag |

## Verification
The bench aims at the following corner cases:
- A triangle straddling the x=32 tile boundary. Off-by-one tile arithmetic would drop it from one bucket.
- A triangle lying wholly off-screen. Missing clipping would alias it into a real bucket.
- A full-screen triangle followed by eighteen more triangles in one tile. A broken limit would overrun the bucket or lose the earlier entries instead of the late ones.
- A triangle offered during dispatch. A leaky ready signal would inflate a bucket count.
- Ports that finish at staggered times. A design that hands a bucket to a busy port, or to a higher port ahead of a lower one, is caught by the per-grant port check.
- An empty frame. A design that waits for a grant before completing would never pulse frame-done.

// File: rtl/tile_binner.sv
module tile_binner #(
  parameter int TILES_X   = 6,
  parameter int TILES_Y   = 4,
  parameter int DEPTH     = 16,
  parameter int N_RAST    = 4,
  parameter int IDX_W     = 8,
  parameter int PX_W      = 10,
  parameter int TILE_LOG2 = 5,
  localparam int NT  = TILES_X * TILES_Y,
  localparam int TW  = $clog2(NT),
  localparam int SW  = $clog2(DEPTH),
  localparam int CW  = $clog2(DEPTH + 1),
  localparam int TCW = PX_W - TILE_LOG2,
  localparam int PW  = $clog2(N_RAST)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tri_valid,
  output logic              tri_ready,
  input  logic [IDX_W-1:0]  tri_id,
  input  logic [PX_W-1:0]   v0_x,
  input  logic [PX_W-1:0]   v0_y,
  input  logic [PX_W-1:0]   v1_x,
  input  logic [PX_W-1:0]   v1_y,
  input  logic [PX_W-1:0]   v2_x,
  input  logic [PX_W-1:0]   v2_y,
  input  logic              frame_end,
  input  logic [N_RAST-1:0] rast_req,
  output logic [N_RAST-1:0] grant_vec,
  output logic [TW-1:0]     grant_tile,
  output logic [CW-1:0]     grant_count,
  input  logic [TW-1:0]     rd_tile,
  input  logic [SW-1:0]     rd_slot,
  output logic [IDX_W-1:0]  rd_idx,
  output logic              frame_done,
  output logic              overflow_err
);

  typedef enum logic {BIN, DISP} phase_t;
  phase_t phase;

  logic [IDX_W-1:0]       mem [NT][DEPTH];
  logic [NT-1:0][CW-1:0]  cnt;
  logic [NT-1:0]          hit, full, taken, pend;
  logic [N_RAST-1:0]      busy, elig;
  logic [TW-1:0]          ptile;
  logic [PW-1:0]          pport;
  logic                   have_t, have_p, accept, done_now;
  logic [PX_W-1:0]        bx0, bx1, by0, by1;

  function automatic logic [PX_W-1:0] lo3(input logic [PX_W-1:0] a, b, c);
    logic [PX_W-1:0] m;
    m = (a < b) ? a : b;
    return (m < c) ? m : c;
  endfunction

  function automatic logic [PX_W-1:0] hi3(input logic [PX_W-1:0] a, b, c);
    logic [PX_W-1:0] m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  assign bx0 = lo3(v0_x, v1_x, v2_x);
  assign bx1 = hi3(v0_x, v1_x, v2_x);
  assign by0 = lo3(v0_y, v1_y, v2_y);
  assign by1 = hi3(v0_y, v1_y, v2_y);

  assign tri_ready = (phase == BIN);
  assign accept    = tri_valid && tri_ready;

  for (genvar r = 0; r < TILES_Y; r++) begin : g_row
    for (genvar c = 0; c < TILES_X; c++) begin : g_col
      assign hit[r*TILES_X+c] = (TCW'(c) >= bx0[PX_W-1:TILE_LOG2]) && (TCW'(c) <= bx1[PX_W-1:TILE_LOG2]) &&
                                (TCW'(r) >= by0[PX_W-1:TILE_LOG2]) && (TCW'(r) <= by1[PX_W-1:TILE_LOG2]);
    end
  end

  always_comb begin
    for (int t = 0; t < NT; t++) begin
      full[t] = (cnt[t] == CW'(DEPTH));
      pend[t] = (phase == DISP) && (cnt[t] != '0) && !taken[t];
    end
  end

  assign elig     = rast_req & ~busy;
  assign done_now = (phase == DISP) && (pend == '0) && (busy == '0);

  always_comb begin
    ptile  = '0;
    have_t = 1'b0;
    for (int i = NT - 1; i >= 0; i--)
      if (pend[i]) begin
        ptile  = TW'(i);
        have_t = 1'b1;
      end
    pport  = '0;
    have_p = 1'b0;
    for (int i = N_RAST - 1; i >= 0; i--)
      if (elig[i]) begin
        pport  = PW'(i);
        have_p = 1'b1;
      end
  end

  always_ff @(posedge clk) begin
    for (int t = 0; t < NT; t++)
      if (accept && hit[t] && !full[t]) mem[t][cnt[t][SW-1:0]] <= tri_id;
  end

  assign rd_idx = (32'(rd_tile) < NT) ? mem[rd_tile][rd_slot] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase        <= BIN;
      cnt          <= '0;
      taken        <= '0;
      busy         <= '0;
      grant_vec    <= '0;
      grant_tile   <= '0;
      grant_count  <= '0;
      frame_done   <= 1'b0;
      overflow_err <= 1'b0;
    end else begin
      grant_vec    <= '0;
      frame_done   <= 1'b0;
      busy         <= busy & ~rast_req;
      overflow_err <= overflow_err | (accept && |(hit & full));
      for (int t = 0; t < NT; t++)
        if (accept && hit[t] && !full[t]) cnt[t] <= cnt[t] + 1'b1;
      if (phase == BIN && frame_end) phase <= DISP;
      if (have_t && have_p) begin
        grant_vec[pport] <= 1'b1;
        grant_tile       <= ptile;
        grant_count      <= cnt[ptile];
        taken[ptile]     <= 1'b1;
        busy[pport]      <= 1'b1;
      end
      if (done_now) begin
        phase      <= BIN;
        frame_done <= 1'b1;
        cnt        <= '0;
        taken      <= '0;
      end
    end
  end

  AST_READY_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n) tri_ready |-> grant_vec == '0); // R3
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant_vec)); // R4
  AST_GRANT_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n) (|grant_vec) |-> (grant_vec & ~$past(rast_req)) == '0); // R4
  AST_GRANT_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n) (|grant_vec) |-> grant_count != '0); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) overflow_err |=> overflow_err); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) frame_done |=> !frame_done); // R8
  AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n) frame_done |-> tri_ready); // R8

endmodule

// File: tb/sim_tile_binner.sv
`timescale 1ns/100ps
module sim_tile_binner;
  localparam int NT = 24;
  localparam int NP = 4;

  logic clk = 0, rst_n = 0;
  logic tri_valid = 0, frame_end = 0;
  logic tri_ready;
  logic [7:0] tri_id = 0;
  logic [9:0] v0_x = 0, v0_y = 0, v1_x = 0, v1_y = 0, v2_x = 0, v2_y = 0;
  logic [NP-1:0] rast_req = '1;
  logic [NP-1:0] grant_vec;
  logic [4:0] grant_tile, grant_count;
  logic [4:0] rd_tile = 0;
  logic [3:0] rd_slot = 0;
  logic [7:0] rd_idx;
  logic frame_done, overflow_err;

  always #5 clk = ~clk;

  tile_binner u0 (.clk, .rst_n, .tri_valid, .tri_ready, .tri_id, .v0_x, .v0_y, .v1_x, .v1_y,
    .v2_x, .v2_y, .frame_end, .rast_req, .grant_vec, .grant_tile, .grant_count, .rd_tile,
    .rd_slot, .rd_idx, .frame_done, .overflow_err);

  int total = 0, bad = 0;
  int exp_q [NT][$];
  bit got [NT];
  bit exp_err = 0, done_seen = 0, finished = 0;
  int last_tile = -1, ngrants = 0;
  int timer [NP];
  int age [NP];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // driver: pushes expected bucket entries, then presents the triangle
  task automatic send_tri(input int id, input int x0, y0, x1, y1, x2, y2);
    int lx, hx, ly, hy;
    lx = (x0 < x1 ? x0 : x1); lx = (lx < x2 ? lx : x2);
    hx = (x0 > x1 ? x0 : x1); hx = (hx > x2 ? hx : x2);
    ly = (y0 < y1 ? y0 : y1); ly = (ly < y2 ? ly : y2);
    hy = (y0 > y1 ? y0 : y1); hy = (hy > y2 ? hy : y2);
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 6; c++)
        if (c >= lx / 32 && c <= hx / 32 && r >= ly / 32 && r <= hy / 32) begin
          if (exp_q[r*6+c].size() < 16) exp_q[r*6+c].push_back(id);
          else exp_err = 1;
        end
    chk(tri_ready == 1'b1, "R3 ready in binning", int'(tri_ready), 1);
    tri_id = 8'(id);
    v0_x = 10'(x0); v0_y = 10'(y0); v1_x = 10'(x1); v1_y = 10'(y1); v2_x = 10'(x2); v2_y = 10'(y2);
    tri_valid = 1;
    @(negedge clk);
    tri_valid = 0;
  endtask

  task automatic start_frame();
    for (int t = 0; t < NT; t++) begin
      exp_q[t].delete();
      got[t] = 0;
    end
    last_tile = -1;
    ngrants = 0;
    done_seen = 0;
  endtask

  task automatic close_frame(input bit inject);
    frame_end = 1;
    @(negedge clk);
    frame_end = 0;
    if (inject) begin
      tri_id = 99; v0_x = 0; v0_y = 0; v1_x = 191; v1_y = 0; v2_x = 0; v2_y = 127;
      tri_valid = 1;
      for (int i = 0; i < 3; i++) begin
        chk(tri_ready == 1'b0, "R3 not ready in dispatch", int'(tri_ready), 0);
        @(negedge clk);
      end
      tri_valid = 0;
    end
    for (int i = 0; i < 3000 && !done_seen; i++) @(negedge clk);
    chk(done_seen, "R8 frame completes", int'(done_seen), 1);
    chk(overflow_err == exp_err, "R7 overflow flag", int'(overflow_err), int'(exp_err));
  endtask

  // monitor: compares grants and bucket contents against the scoreboard; models ports
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit gone;
      gone = 0;
      if (grant_vec != '0) begin
        int p, ep, tl;
        p = -1; ep = -1;
        for (int i = NP - 1; i >= 0; i--) if (grant_vec[i]) p = i;
        for (int i = NP - 1; i >= 0; i--) if (rast_req[i] && age[i] >= 1) ep = i;
        chk($countones(grant_vec) == 1, "R4 one grant", $countones(grant_vec), 1);
        chk(p == ep, "R4 lowest eligible port", p, ep);
        chk(rast_req[p] && timer[p] == 0, "R6 port free when granted", int'(rast_req[p]), 1);
        tl = int'(grant_tile);
        chk(tl > last_tile, "R4 ascending tiles", tl, last_tile + 1);
        chk(tl < NT && !got[tl], "R5 bucket granted once", tl, tl);
        if (tl < NT) begin
          got[tl] = 1;
          chk(exp_q[tl].size() != 0, "R5 non-empty grant", int'(grant_count), 1);
          chk(int'(grant_count) == exp_q[tl].size(), "R1 bucket count", int'(grant_count), exp_q[tl].size());
        end
        last_tile = tl;
        ngrants++;
        rast_req[p] = 0;
        timer[p] = p + 2;
        gone = 1;
        if (tl < NT) begin
          for (int s = 0; s < exp_q[tl].size(); s++) begin
            rd_tile = 5'(tl);
            rd_slot = 4'(s);
            #0.2;
            chk(int'(rd_idx) == exp_q[tl][s], "R2 entry order", int'(rd_idx), exp_q[tl][s]);
          end
        end
      end
      for (int i = 0; i < NP; i++) begin
        if (gone && !rast_req[i] && timer[i] == i + 2 && grant_vec[i]) continue;
        if (rast_req[i]) age[i]++;
        else if (timer[i] > 0) begin
          timer[i]--;
          if (timer[i] == 0) begin
            rast_req[i] = 1;
            age[i] = 0;
          end
        end
      end
      if (frame_done) begin
        int ne;
        ne = 0;
        for (int t = 0; t < NT; t++) if (exp_q[t].size() != 0) ne++;
        done_seen = 1;
        chk(ngrants == ne, "R5 grants equal non-empty buckets", ngrants, ne);
        chk(rast_req == '1, "R8 all ports finished", int'(rast_req), 15);
        chk(tri_ready == 1'b1, "R8 back to binning", int'(tri_ready), 1);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      chk(0, "watchdog", 0, 1);
      summary();
    end
  end

  initial begin
    for (int i = 0; i < NP; i++) begin
      timer[i] = 0;
      age[i] = 100;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state
    chk(tri_ready == 1'b1, "R9 ready", int'(tri_ready), 1);
    chk(grant_vec == '0, "R9 no grant", int'(grant_vec), 0);
    chk(frame_done == 1'b0, "R9 done low", int'(frame_done), 0);
    chk(overflow_err == 1'b0, "R9 err low", int'(overflow_err), 0);

    // frame 1: mixed sizes, boundary straddle, off-screen, sparse buckets (R1 R2 R5)
    start_frame();
    send_tri(1, 3, 4, 10, 4, 5, 20);
    send_tri(2, 40, 10, 90, 5, 60, 50);
    send_tri(3, 900, 10, 950, 10, 920, 40);
    send_tri(4, 170, 100, 180, 110, 175, 120);
    send_tri(5, 31, 33, 32, 40, 31, 45);
    send_tri(6, 70, 50, 75, 60, 80, 55);
    repeat (2) @(negedge clk);
    chk(grant_vec == '0, "R3 no grant while binning", int'(grant_vec), 0);
    close_frame(0);

    // frame 2: full-screen triangle, overflow of one bucket, ignored input during dispatch (R3 R7)
    start_frame();
    send_tri(10, 0, 0, 191, 0, 0, 127);
    for (int k = 0; k < 18; k++) send_tri(20 + k, 40, 40, 50, 40, 45, 50);
    close_frame(1);

    // frame 3: empty frame (R8)
    start_frame();
    close_frame(0);
    chk(ngrants == 0, "R8 empty frame no grants", ngrants, 0);

    repeat (5) @(negedge clk);
    finished = 1;
    summary();
  end
endmodule